// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the register front end of one bus-master DMA channel that serves a single peripheral. A host reaches four 32-bit words through a slave port that accepts only full-word writes: a control/status word, a running transfer address, a byte count and an upper-address base. Reads return the selected word combinationally. The data mover and any address translation sit outside the block. The block only holds the channel state and produces the control outputs.

The control/status word carries the interrupt pending and interrupt enable flags, a FIFO drain flag, a peripheral reset request, the transfer direction, the channel enable and an address-loaded flag. Some of its bits cannot be written, and a fixed version code is always present. The host interrupt line is registered and is high exactly when the pending and enable flags are both set. A control write that carries the reset request produces a one-cycle pulse on the peripheral reset output.

The pulse comes from a two-state machine. PR_IDLE keeps the output low. The transition PR_IDLE to PR_PULSE is taken on a control write with bit 7 set. PR_PULSE drives the output high for one cycle. From PR_PULSE the machine returns to PR_IDLE, or it stays in PR_PULSE when another such write arrives in that cycle. Each completed peripheral transfer adds its length in bytes to the address word.

Top module: `dmach_regs`

## Requirements
- R1: After reset, word 0 reads 0xA0000000, words 1 to 3 read 0, and host_irq, per_rst and dma_en are low.
- R2: bus_addr (byte address bits [3:2]) selects the word: 0 is control/status, 1 is address, 2 is count and 3 is base. A write takes effect only when all four bits of bus_be are set. Any other byte-enable pattern leaves every word unchanged.
- R3: On a control write, the bits in mask 0xFE000007 keep their old value and 0xA0000000 is ORed into the stored word. All other bits take the written value, except for bit 6, which follows R4.
- R4: Drain bit 6 on a control write: with bit 7 written as 1, bit 6 is stored as written. Otherwise a written 1 is stored as 0. Otherwise, if the whole written value is zero, bit 6 is stored as 1.
- R5: Interrupt pending bit 0 sets at the clock edge where per_irq is first seen high, and clears at the edge where per_irq is first seen low.
- R6: After every clock edge, host_irq equals pending bit 0 AND enable bit 4 of the stored control word.
- R7: A control write with bit 7 set drives per_rst high for exactly the one cycle that follows the write edge.
- R8: dma_en rises when a control write turns bit 9 from 0 to 1, and falls when a control write turns it from 1 to 0.
- R9: Any write to word 1 sets bit 26 (address loaded) of the control word. Only reset clears that bit.
- R10: A cycle with xfer_done high adds xfer_len to word 1. A host write to word 1 in the same cycle wins, and the written value is stored instead.
- R11: Words 2 and 3 store and return the full written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte enables; all four must be set for a write to take effect |
| bus_addr | input | 2 | Byte address bits [3:2], word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Selected word, combinational |
| per_irq | input | 1 | Interrupt level from the peripheral |
| xfer_done | input | 1 | One completed peripheral transfer this cycle |
| xfer_len | input | LEN_W | Length in bytes of the completed transfer |
| host_irq | output | 1 | Registered host interrupt line |
| per_rst | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en | output | 1 | Channel enable to the data mover |

## Verification
A write, a per_irq level change or an xfer_done strobe is sampled at one rising edge. Every stored word, host_irq, dma_en and per_rst then show the result right after that edge, so the result is due one cycle after the input is driven. Read data depends only on bus_addr and the stored words, with no added delay. The bench drives inputs just after a rising edge. It updates a behavioural model at each rising edge and compares all outputs and the selected word at the following falling edge. Directed checks sample at the same falling edge, which is the first one after the capturing edge, and a second sample one cycle later confirms that the reset pulse has ended.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam logic [WORD_W-1:0] CSR_VERSION = 32'hA000_0000;
    localparam logic [WORD_W-1:0] CSR_LOCKED  = 32'hFE00_0007;

    localparam int unsigned B_PEND   = 0;
    localparam int unsigned B_IEN    = 4;
    localparam int unsigned B_DRAIN  = 6;
    localparam int unsigned B_PRST   = 7;
    localparam int unsigned B_TOMEM  = 8;
    localparam int unsigned B_CHEN   = 9;
    localparam int unsigned B_LOADED = 26;

    typedef enum logic [1:0] {
        W_CSR   = 2'd0,
        W_ADDR  = 2'd1,
        W_COUNT = 2'd2,
        W_BASE  = 2'd3
    } word_e;

    typedef enum logic {
        PR_IDLE  = 1'b0,
        PR_PULSE = 1'b1
    } prst_state_e;
endpackage

// File: rtl/dmach_csr_unit.sv
module dmach_csr_unit
    import dmach_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              addr_loaded,
    input  logic              per_irq,
    output logic [WORD_W-1:0] csr_q,
    output logic              host_irq,
    output logic              per_rst,
    output logic              dma_en
);
    prst_state_e       state_q, state_d;
    logic [WORD_W-1:0] csr_d;
    logic [WORD_W-1:0] wr_val;
    logic              irq_prev, irq_rise, irq_fall;
    logic              host_irq_d, dma_en_d;
    logic              reset_req;

    assign irq_rise  = per_irq & ~irq_prev;
    assign irq_fall  = ~per_irq & irq_prev;
    assign reset_req = csr_wr & wdata[B_PRST];

    // drain rule on the written value
    always_comb begin
        wr_val = wdata;
        if (!wdata[B_PRST]) begin
            if (wdata[B_DRAIN])
                wr_val[B_DRAIN] = 1'b0;
            else if (wdata == '0)
                wr_val[B_DRAIN] = 1'b1;
        end
    end

    always_comb begin
        csr_d = csr_q;
        if (csr_wr)
            csr_d = (csr_q & CSR_LOCKED) | (wr_val & ~CSR_LOCKED) | CSR_VERSION;
        if (addr_loaded)
            csr_d[B_LOADED] = 1'b1;
        if (irq_rise)
            csr_d[B_PEND] = 1'b1;
        else if (irq_fall && csr_q[B_PEND])
            csr_d[B_PEND] = 1'b0;
    end

    // host line moves on enable writes and on interrupt edges
    always_comb begin
        host_irq_d = host_irq;
        if (csr_wr) begin
            if (wdata[B_IEN]) begin
                if (csr_q[B_PEND])
                    host_irq_d = 1'b1;
            end else begin
                host_irq_d = 1'b0;
            end
        end
        if (irq_rise && csr_d[B_IEN])
            host_irq_d = 1'b1;
        else if (irq_fall && csr_q[B_PEND] && csr_d[B_IEN])
            host_irq_d = 1'b0;
    end

    always_comb begin
        dma_en_d = dma_en;
        if (csr_wr && wdata[B_CHEN] && !csr_q[B_CHEN])
            dma_en_d = 1'b1;
        else if (csr_wr && !wdata[B_CHEN] && csr_q[B_CHEN])
            dma_en_d = 1'b0;
    end

    always_comb begin
        state_d = PR_IDLE;
        unique case (state_q)
            PR_IDLE:  state_d = reset_req ? PR_PULSE : PR_IDLE;
            PR_PULSE: state_d = reset_req ? PR_PULSE : PR_IDLE;
            default:  state_d = PR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PR_IDLE;
            csr_q    <= CSR_VERSION;
            irq_prev <= 1'b0;
            host_irq <= 1'b0;
            dma_en   <= 1'b0;
        end else begin
            state_q  <= state_d;
            csr_q    <= csr_d;
            irq_prev <= per_irq;
            host_irq <= host_irq_d;
            dma_en   <= dma_en_d;
        end
    end

    always_comb begin
        per_rst = 1'b0;
        unique case (state_q)
            PR_IDLE:  per_rst = 1'b0;
            PR_PULSE: per_rst = 1'b1;
            default:  per_rst = 1'b0;
        endcase
    end

    a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == (csr_q[B_PEND] && csr_q[B_IEN]));
    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        per_rst |-> $past(csr_wr && wdata[B_PRST]));
    a_r4_zero_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && wdata == '0) |=> csr_q[B_DRAIN]);
    a_r9_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        addr_loaded |=> csr_q[B_LOADED]);
endmodule

// File: rtl/dmach_ptr_unit.sv
module dmach_ptr_unit
    import dmach_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic [WORD_W-1:0] addr_q
);
    localparam int unsigned PAD_W = WORD_W - LEN_W;

    logic [WORD_W-1:0] len_ext;
    assign len_ext = {{PAD_W{1'b0}}, xfer_len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (wr)
            addr_q <= wdata;
        else if (xfer_done)
            addr_q <= addr_q + len_ext;
    end

    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && xfer_done) |=> addr_q == $past(addr_q) + $past(len_ext));
    a_r10_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> addr_q == $past(wdata));
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [3:2]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              per_irq,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              host_irq,
    output logic              per_rst,
    output logic              dma_en
);
    localparam int unsigned NUM_PLAIN   = 2;
    localparam int unsigned FIRST_PLAIN = 2;

    logic                               wr_ok;
    logic [WORD_W-1:0]                  csr_q, addr_q;
    logic [NUM_PLAIN-1:0][WORD_W-1:0]   plain_w;

    assign wr_ok = bus_wr && (bus_be == 4'hF);

    dmach_csr_unit u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_wr      (wr_ok && bus_addr == W_CSR),
        .wdata       (bus_wdata),
        .addr_loaded (wr_ok && bus_addr == W_ADDR),
        .per_irq     (per_irq),
        .csr_q       (csr_q),
        .host_irq    (host_irq),
        .per_rst     (per_rst),
        .dma_en      (dma_en)
    );

    dmach_ptr_unit #(.LEN_W(LEN_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_ok && bus_addr == W_ADDR),
        .wdata     (bus_wdata),
        .xfer_done (xfer_done),
        .xfer_len  (xfer_len),
        .addr_q    (addr_q)
    );

    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_ok && bus_addr == 2'(FIRST_PLAIN + g))
                q <= bus_wdata;
        end
        assign plain_w[g] = q;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (word_e'(bus_addr))
            W_CSR:   bus_rdata = csr_q;
            W_ADDR:  bus_rdata = addr_q;
            W_COUNT: bus_rdata = plain_w[0];
            W_BASE:  bus_rdata = plain_w[1];
            default: bus_rdata = '0;
        endcase
    end

    a_r2_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be != 4'hF && !xfer_done && per_irq == $past(per_irq))
        |=> $stable(plain_w));
endmodule

// File: tb/dmach_regs_tb_top.sv
`timescale 1ns/1ps
module dmach_regs_tb_top;
    localparam int LEN_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = 4'h0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        per_irq = 1'b0;
    logic        xfer_done = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic        host_irq, per_rst, dma_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dmach_regs #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_irq(per_irq), .xfer_done(xfer_done), .xfer_len(xfer_len),
        .host_irq(host_irq), .per_rst(per_rst), .dma_en(dma_en)
    );

    // behavioural reference, one update per rising edge
    logic [31:0] m_word [4];
    logic m_irq, m_prst, m_en, m_prev;

    always @(posedge clk) begin : model
        logic [31:0] v, nc;
        logic wr;
        if (!rst_n) begin
            m_word[0] = 32'hA000_0000;
            m_word[1] = 0; m_word[2] = 0; m_word[3] = 0;
            m_irq = 0; m_prst = 0; m_en = 0; m_prev = 0;
        end else begin
            wr = bus_wr && bus_be == 4'hF;
            nc = m_word[0];
            m_prst = 0;
            if (wr && bus_addr == 0) begin
                v = bus_wdata;
                m_prst = v[7];
                if (!v[7]) begin
                    if (v[6]) v[6] = 0;
                    else if (v == 0) v[6] = 1;
                end
                nc = {m_word[0][31:25], v[24:3], m_word[0][2:0]} | 32'hA000_0000;
            end
            if (wr && bus_addr == 1) begin
                m_word[1] = bus_wdata;
                nc[26] = 1;
            end else if (xfer_done) begin
                m_word[1] = m_word[1] + 32'(xfer_len);
            end
            if (wr && bus_addr >= 2) m_word[bus_addr] = bus_wdata;
            if (per_irq && !m_prev) nc[0] = 1;
            if (!per_irq && m_prev) nc[0] = 0;
            m_word[0] = nc;
            m_irq = nc[0] & nc[4];
            m_en = nc[9];
            m_prev = per_irq;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(bus_rdata == m_word[bus_addr],
                bus_addr == 0 ? "R3 model word0" : bus_addr == 1 ? "R10 model word1" : "R11 model plain word",
                bus_rdata, m_word[bus_addr]);
            chk(host_irq == m_irq, "R6 model host_irq", 32'(host_irq), 32'(m_irq));
            chk(per_rst == m_prst, "R7 model per_rst", 32'(per_rst), 32'(m_prst));
            chk(dma_en == m_en, "R8 model dma_en", 32'(dma_en), 32'(m_en));
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic bwrite(input logic [1:0] w, input logic [31:0] d, input logic [3:0] be);
        bus_wr = 1; bus_addr = w; bus_wdata = d; bus_be = be;
        cyc();
        bus_wr = 0; bus_be = 4'h0;
    endtask

    task automatic expect_word(input logic [1:0] w, input logic [31:0] exp, input string tag);
        bus_addr = w;
        @(negedge clk);
        chk(bus_rdata == exp, tag, bus_rdata, exp);
        cyc();
    endtask

    task automatic expect_all(input logic [1:0] w, input logic [31:0] exp,
                              input logic e_irq, input logic e_prst, input logic e_en, input string tag);
        bus_addr = w;
        @(negedge clk);
        chk(bus_rdata == exp, tag, bus_rdata, exp);
        chk(host_irq == e_irq, {tag, " host_irq"}, 32'(host_irq), 32'(e_irq));
        chk(per_rst == e_prst, {tag, " per_rst"}, 32'(per_rst), 32'(e_prst));
        chk(dma_en == e_en, {tag, " dma_en"}, 32'(dma_en), 32'(e_en));
        cyc();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cyc();
        // R1 reset state
        expect_all(0, 32'hA000_0000, 0, 0, 0, "R1 reset csr");
        expect_word(1, 0, "R1 reset addr");
        expect_word(2, 0, "R1 reset count");
        expect_word(3, 0, "R1 reset base");
        // R4 drain rules
        bwrite(0, 32'h0, 4'hF);
        expect_word(0, 32'hA000_0040, "R4 zero write sets drain");
        bwrite(0, 32'h40, 4'hF);
        expect_word(0, 32'hA000_0000, "R4 drain written one stored zero");
        // R3 locked bits, R7 pulse, R8 enable rise
        bwrite(0, 32'hFFFF_FFFF, 4'hF);
        expect_all(0, 32'hA1FF_FFF8, 0, 1, 1, "R3 R7 all ones write");
        expect_all(0, 32'hA1FF_FFF8, 0, 0, 1, "R7 pulse ended");
        // R8 enable fall
        bwrite(0, 32'h10, 4'hF);
        expect_all(0, 32'hA000_0010, 0, 0, 0, "R8 enable cleared");
        // R5 R6 interrupt rise with enable set
        per_irq = 1; cyc();
        expect_all(0, 32'hA000_0011, 1, 0, 0, "R5 pending set");
        bwrite(0, 32'h0, 4'hF);
        expect_all(0, 32'hA000_0041, 0, 0, 0, "R6 enable clear lowers");
        bwrite(0, 32'h10, 4'hF);
        expect_all(0, 32'hA000_0011, 1, 0, 0, "R6 enable with pending raises");
        per_irq = 0; cyc();
        expect_all(0, 32'hA000_0010, 0, 0, 0, "R5 pending cleared");
        // R2 partial write ignored
        bwrite(2, 32'hDEAD_BEEF, 4'h3);
        expect_word(2, 0, "R2 partial write ignored");
        // R9 R10
        bwrite(1, 32'h0000_1000, 4'hF);
        expect_word(1, 32'h0000_1000, "R10 address write");
        expect_word(0, 32'hA400_0010, "R9 loaded bit");
        xfer_done = 1; xfer_len = 16'h20; cyc();
        xfer_done = 0;
        expect_word(1, 32'h0000_1020, "R10 single increment");
        xfer_done = 1; xfer_len = 16'h4; cyc();
        xfer_len = 16'h8; cyc();
        xfer_done = 0;
        expect_word(1, 32'h0000_102C, "R10 back to back increments");
        xfer_done = 1; xfer_len = 16'h4;
        bwrite(1, 32'h0000_5000, 4'hF);
        xfer_done = 0;
        expect_word(1, 32'h0000_5000, "R10 host write wins");
        // R11 plain words
        bwrite(2, 32'h1234_5678, 4'hF);
        bwrite(3, 32'h8765_4321, 4'hF);
        expect_word(2, 32'h1234_5678, "R11 count word");
        expect_word(3, 32'h8765_4321, "R11 base word");
        // R7 back-to-back reset writes, R4 drain kept with reset bit
        bwrite(0, 32'hC0, 4'hF);
        expect_all(0, 32'hA400_00C0, 0, 1, 0, "R4 R7 reset keeps drain");
        repeat (5) cyc();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule